// File: doc/BRIEF.md
# Quasi-Cyclic LDPC Rate-2/3 Systematic Encoder

This block turns a serial stream of 4096 information bits into a 6144-bit rate-2/3 codeword. The parity half of the generator is made of 256x256 circulant sub-matrices arranged in 16 block columns (one per group of 256 information bits) and 8 block rows (one per 256-bit parity segment). Only one row of each circulant is held, as a constant parameter. The block keeps eight rotating row registers and eight 256-bit parity accumulators, and the full generator is never stored. The rotating rows advance by one cyclic position for each accepted information bit, and reload from the parameter at every block-column boundary.

The information bits flow through to the output unchanged, in the same cycle they are accepted, under a valid/ready handshake on both sides. After the 4096th information bit the input is closed and the 2048 parity bits are streamed out. The last of them is flagged, and the encoder then returns to accepting a fresh block with cleared accumulators.

Top module: `qc_ldpc_encoder`

## Requirements
- R1: Out of reset the encoder is at the start of a block, holding no parity, with `out_valid` low while `in_valid` is low and `out_last` low.
- R2: For the first 4096 outputs of a block, `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and `out_bit` equals `in_bit`, so each information bit appears unchanged and in order in the cycle it is accepted.
- R3: The row used for information bit i (i = 0..4095) in parity segment p (p = 0..7) is the stored row of circulant (c = i / 256, p) rotated right cyclically by i mod 256 places, where one right rotation moves bit k+1 into bit k and bit 0 into bit 255. The stored row of circulant (c, p) sits at `FIRST_ROWS[(c*8+p)*256 +: 256]`.
- R4: Parity segment p is the XOR of the rows of R3 over all information bits equal to 1, and an information bit of 0 changes no segment.
- R5: After the 4096 information bits, the block sends 2048 parity bits: segment 0 first through segment 7 last, each from bit 255 down to bit 0. `out_valid` stays high and `in_ready` stays low throughout this phase.
- R6: `out_last` is high exactly on the 6144th output of a block and on no other output.
- R7: Each block's parity depends only on that block's information bits. This holds for blocks sent back to back and after a reset taken part-way through a block.
- R8: While a parity bit is offered and `out_ready` is low, `out_bit` holds its value into the next cycle and no parity bit is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Information bit offered |
| in_ready | output | 1 | Encoder can take an information bit |
| in_bit | input | 1 | Information bit |
| out_valid | output | 1 | Codeword bit offered |
| out_ready | input | 1 | Downstream takes the codeword bit |
| out_bit | output | 1 | Codeword bit, information first then parity |
| out_last | output | 1 | Final parity bit of the codeword |

## Verification
The hardest situation to reach is a single information bit sitting on a block-column boundary, at positions 255, 256 and 4095. An error in the rotation count or in the reload of the next column's stored rows then shows up in only one parity pattern, and denser inputs can hide it. The vector table therefore contains single-one blocks at these positions, alongside all-zero, all-one, alternating and pseudo-random blocks. Two of the pseudo-random blocks throttle both `in_valid` and `out_ready`, so that stalls land inside the parity phase and at the turn from information to parity. A reset taken after a partial block shows that no earlier state leaks into the next codeword.

// File: rtl/qc_enc_pkg.sv
package qc_enc_pkg;

    localparam int DEF_CIRC      = 256;
    localparam int DEF_INFO_BLKS = 16;
    localparam int DEF_PAR_BLKS  = 8;
    localparam int DEF_ENTRIES   = DEF_INFO_BLKS * DEF_PAR_BLKS;
    localparam int DEF_ROW_BITS  = DEF_ENTRIES * DEF_CIRC;

    // Default circulant rows: a xorshift sequence, 32 bits at a time.
    function automatic logic [DEF_ROW_BITS-1:0] default_rows();
        logic [DEF_ROW_BITS-1:0] rows;
        logic [31:0]             s;
        rows = '0;
        s    = 32'h1d87_2b41;
        for (int e = 0; e < DEF_ENTRIES; e++) begin
            for (int w = 0; w < DEF_CIRC / 32; w++) begin
                s = s ^ (s << 13);
                s = s ^ (s >> 17);
                s = s ^ (s << 5);
                rows[e*DEF_CIRC + w*32 +: 32] = s;
            end
        end
        return rows;
    endfunction

endpackage

// File: rtl/qc_enc_lane.sv
module qc_enc_lane #(
    parameter int CIRC      = 256,
    parameter int INFO_BLKS = 16,
    localparam int CW       = (INFO_BLKS > 1) ? $clog2(INFO_BLKS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [INFO_BLKS*CIRC-1:0] lane_rows,
    input  logic                      step,
    input  logic                      step_bit,
    input  logic                      col_end,
    input  logic [CW-1:0]             next_col,
    input  logic                      restart,
    input  logic                      shift,
    output logic                      par_msb
);

    typedef struct packed {
        logic [CIRC-1:0] rot;
        logic [CIRC-1:0] acc;
    } lane_t;

    lane_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.rot = lane_rows[0 +: CIRC];
            st_d.acc = '0;
        end else if (step) begin
            if (step_bit) begin
                st_d.acc = st_q.acc ^ st_q.rot;
            end
            if (col_end) begin
                st_d.rot = lane_rows[next_col*CIRC +: CIRC];
            end else begin
                st_d.rot = {st_q.rot[0], st_q.rot[CIRC-1:1]};
            end
        end else if (shift) begin
            st_d.acc = {st_q.acc[CIRC-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rot <= lane_rows[0 +: CIRC];
            st_q.acc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign par_msb = st_q.acc[CIRC-1];

endmodule

// File: rtl/qc_enc_ctrl.sv
module qc_enc_ctrl #(
    parameter int CIRC      = 256,
    parameter int INFO_BLKS = 16,
    parameter int PAR_BLKS  = 8,
    localparam int CW       = (INFO_BLKS > 1) ? $clog2(INFO_BLKS) : 1,
    localparam int ZW       = $clog2(CIRC),
    localparam int PW       = (PAR_BLKS > 1) ? $clog2(PAR_BLKS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_bit,
    input  logic                out_ready,
    input  logic [PAR_BLKS-1:0] par_msb,
    output logic                in_ready,
    output logic                out_valid,
    output logic                out_bit,
    output logic                out_last,
    output logic                step,
    output logic                step_bit,
    output logic                col_end,
    output logic [CW-1:0]       next_col,
    output logic                restart,
    output logic [PAR_BLKS-1:0] shift_sel
);

    typedef enum logic {PH_INFO = 1'b0, PH_PAR = 1'b1} phase_e;

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] col;
        logic [ZW-1:0] pos;
        logic [PW-1:0] blk;
        logic [ZW-1:0] bidx;
    } ctrl_t;

    localparam logic [ZW-1:0] POS_LAST = ZW'(CIRC - 1);
    localparam logic [CW-1:0] COL_LAST = CW'(INFO_BLKS - 1);
    localparam logic [PW-1:0] BLK_LAST = PW'(PAR_BLKS - 1);

    ctrl_t st_q, st_d;
    logic  take, send, seg_end;

    always_comb begin
        st_d      = st_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_bit   = 1'b0;
        out_last  = 1'b0;
        restart   = 1'b0;
        shift_sel = '0;
        take      = 1'b0;
        send      = 1'b0;
        col_end   = (st_q.pos == POS_LAST);
        next_col  = (st_q.col == COL_LAST) ? '0 : st_q.col + 1'b1;
        seg_end   = (st_q.bidx == POS_LAST);

        if (st_q.phase == PH_INFO) begin
            in_ready  = out_ready;
            out_valid = in_valid;
            out_bit   = in_bit;
            take      = in_valid && out_ready;
            if (take) begin
                st_d.pos = st_q.pos + 1'b1;
                if (col_end) begin
                    st_d.col = next_col;
                    if (st_q.col == COL_LAST) begin
                        st_d.phase = PH_PAR;
                    end
                end
            end
        end else begin
            out_valid = 1'b1;
            out_bit   = par_msb[st_q.blk];
            out_last  = seg_end && (st_q.blk == BLK_LAST);
            send      = out_ready;
            if (send) begin
                shift_sel[st_q.blk] = 1'b1;
                st_d.bidx = st_q.bidx + 1'b1;
                if (seg_end) begin
                    st_d.blk = st_q.blk + 1'b1;
                    if (st_q.blk == BLK_LAST) begin
                        restart    = 1'b1;
                        shift_sel  = '0;
                        st_d.phase = PH_INFO;
                        st_d.col   = '0;
                        st_d.pos   = '0;
                        st_d.blk   = '0;
                        st_d.bidx  = '0;
                    end
                end
            end
        end
        step     = take;
        step_bit = in_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_INFO;
            st_q.col   <= '0;
            st_q.pos   <= '0;
            st_q.blk   <= '0;
            st_q.bidx  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/qc_ldpc_encoder.sv
module qc_ldpc_encoder #(
    parameter int CIRC      = qc_enc_pkg::DEF_CIRC,
    parameter int INFO_BLKS = qc_enc_pkg::DEF_INFO_BLKS,
    parameter int PAR_BLKS  = qc_enc_pkg::DEF_PAR_BLKS,
    parameter logic [INFO_BLKS*PAR_BLKS*CIRC-1:0] FIRST_ROWS = qc_enc_pkg::default_rows()
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    input  logic in_bit,
    output logic out_valid,
    input  logic out_ready,
    output logic out_bit,
    output logic out_last
);

    localparam int CW = (INFO_BLKS > 1) ? $clog2(INFO_BLKS) : 1;

    logic                step, step_bit, col_end, restart;
    logic [CW-1:0]       next_col;
    logic [PAR_BLKS-1:0] shift_sel;
    logic [PAR_BLKS-1:0] par_msb;

    qc_enc_ctrl #(
        .CIRC      (CIRC),
        .INFO_BLKS (INFO_BLKS),
        .PAR_BLKS  (PAR_BLKS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .out_ready (out_ready),
        .par_msb   (par_msb),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .out_last  (out_last),
        .step      (step),
        .step_bit  (step_bit),
        .col_end   (col_end),
        .next_col  (next_col),
        .restart   (restart),
        .shift_sel (shift_sel)
    );

    for (genvar p = 0; p < PAR_BLKS; p++) begin : g_lane
        logic [INFO_BLKS*CIRC-1:0] lane_rows;

        for (genvar c = 0; c < INFO_BLKS; c++) begin : g_col
            assign lane_rows[c*CIRC +: CIRC] = FIRST_ROWS[(c*PAR_BLKS + p)*CIRC +: CIRC];
        end

        qc_enc_lane #(
            .CIRC      (CIRC),
            .INFO_BLKS (INFO_BLKS)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .lane_rows (lane_rows),
            .step      (step),
            .step_bit  (step_bit),
            .col_end   (col_end),
            .next_col  (next_col),
            .restart   (restart),
            .shift     (shift_sel[p]),
            .par_msb   (par_msb[p])
        );
    end

endmodule

// File: rtl/qc_ldpc_encoder_chk.sv
module qc_ldpc_encoder_chk #(
    parameter int CIRC      = 256,
    parameter int INFO_BLKS = 16,
    parameter int PAR_BLKS  = 8
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic in_bit,
    input logic out_valid,
    input logic out_ready,
    input logic out_bit,
    input logic out_last
);

    localparam int K_BITS = CIRC * INFO_BLKS;
    localparam int N_BITS = CIRC * (INFO_BLKS + PAR_BLKS);
    localparam int NW     = $clog2(N_BITS + 1);

    logic [NW-1:0] sent_q;
    logic          info_ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sent_q <= '0;
        end else if (out_valid && out_ready) begin
            sent_q <= (sent_q == NW'(N_BITS - 1)) ? '0 : sent_q + 1'b1;
        end
    end

    assign info_ph = (sent_q < NW'(K_BITS));

    AST_INFO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        info_ph |-> (out_valid == in_valid) && (in_ready == out_ready)
                    && (!in_valid || out_bit == in_bit)); // R2

    AST_PARITY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !info_ph |-> out_valid && !in_ready); // R5

    AST_LAST_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (sent_q == NW'(N_BITS - 1))); // R6

    AST_LAST_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sent_q == NW'(N_BITS - 1)) |-> out_last); // R6

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!info_ph && !out_ready) |=> $stable(out_bit) && out_valid); // R8

endmodule

bind qc_ldpc_encoder qc_ldpc_encoder_chk #(
    .CIRC      (CIRC),
    .INFO_BLKS (INFO_BLKS),
    .PAR_BLKS  (PAR_BLKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_bit    (in_bit),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_bit   (out_bit),
    .out_last  (out_last)
);

// File: tb/qc_ldpc_encoder_test.sv
module qc_ldpc_encoder_test;

    localparam int Z  = qc_enc_pkg::DEF_CIRC;
    localparam int KB = qc_enc_pkg::DEF_INFO_BLKS;
    localparam int PB = qc_enc_pkg::DEF_PAR_BLKS;
    localparam int K  = Z * KB;
    localparam int N  = Z * (KB + PB);
    localparam logic [KB*PB*Z-1:0] ROWS = qc_enc_pkg::default_rows();

    // vector: kind[23:21] (0 zeros,1 ones,2 single one at arg,3 pseudo-random seed arg,4 alternating),
    //         arg[20:1], stall[0]
    localparam int NV = 9;
    localparam logic [23:0] VEC [NV] = '{
        {3'd0, 20'd0,      1'b0},
        {3'd1, 20'd0,      1'b0},
        {3'd2, 20'd0,      1'b0},
        {3'd2, 20'd255,    1'b0},
        {3'd2, 20'd256,    1'b0},
        {3'd2, 20'd4095,   1'b0},
        {3'd4, 20'd0,      1'b0},
        {3'd3, 20'h5a5a3,  1'b1},
        {3'd3, 20'h13579,  1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic out_ready = 1'b1;
    logic in_ready, out_valid, out_bit, out_last;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit wd_hit   = 1'b0;

    logic          info_bits [K];
    logic          got_bits  [N];
    logic [Z-1:0]  exp_par   [PB];

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) wd_hit <= 1'b1;
    end

    qc_ldpc_encoder uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_bit    (in_bit),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_bit   (out_bit),
        .out_last  (out_last)
    );

    function automatic logic [31:0] xs(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        return t ^ (t << 5);
    endfunction

    function automatic logic [Z-1:0] rot_r(input logic [Z-1:0] x, input int s);
        logic [Z-1:0] r;
        r = x;
        for (int i = 0; i < s; i++) r = {r[0], r[Z-1:1]};
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [Z-1:0] act, input logic [Z-1:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic build(input int kind, input int arg);
        logic [31:0] s;
        s = 32'(arg) | 32'h1;
        for (int i = 0; i < K; i++) begin
            s = xs(s);
            case (kind)
                0:       info_bits[i] = 1'b0;
                1:       info_bits[i] = 1'b1;
                2:       info_bits[i] = (i == arg);
                3:       info_bits[i] = s[7];
                default: info_bits[i] = i[0];
            endcase
        end
        for (int p = 0; p < PB; p++) exp_par[p] = '0;
        // R3 R4 behavioural product: rotate each stored row by the bit offset in its column
        for (int c = 0; c < KB; c++) begin
            for (int p = 0; p < PB; p++) begin
                logic [Z-1:0] r;
                r = ROWS[(c*PB + p)*Z +: Z];
                for (int j = 0; j < Z; j++) begin
                    if (info_bits[c*Z + j]) exp_par[p] = exp_par[p] ^ r;
                    r = {r[0], r[Z-1:1]};
                end
            end
        end
    endtask

    task automatic run_block(input int kind, input int arg, input bit stall, input int tag);
        int sent = 0;
        int got = 0;
        int last_at = -1;
        int last_cnt = 0;
        int r5_bad = 0;
        int r8_bad = 0;
        bit hold = 1'b0;
        logic hold_bit = 1'b0;
        logic [31:0] lf = 32'h2468_ace1 ^ 32'(tag);
        int info_bad = 0;
        build(kind, arg);
        while (got < N && !wd_hit) begin
            @(negedge clk);
            lf = xs(lf);
            in_valid  = (sent < K) && (!stall || lf[0] || lf[3]);
            in_bit    = (sent < K) ? info_bits[sent] : 1'b0;
            out_ready = !stall || lf[5] || lf[9];
            #1;
            if (hold && out_bit !== hold_bit) r8_bad++;
            if (got >= K && (out_valid !== 1'b1 || in_ready !== 1'b0)) r5_bad++;
            hold     = (got >= K) && !out_ready;
            hold_bit = out_bit;
            if (out_valid && out_ready) begin
                got_bits[got] = out_bit;
                if (out_last) begin
                    last_at = got;
                    last_cnt++;
                end
                got++;
            end
            if (in_valid && in_ready) sent++;
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        for (int i = 0; i < K; i++) if (got_bits[i] !== info_bits[i]) info_bad++;
        check(info_bad == 0, "R2", $sformatf("vec %0d info mismatches", tag),
              Z'(info_bad), '0);
        for (int p = 0; p < PB; p++) begin
            logic [Z-1:0] act;
            for (int k = 0; k < Z; k++) act[Z-1-k] = got_bits[K + p*Z + k];
            check(act === exp_par[p], "R4",
                  $sformatf("vec %0d parity segment %0d (R3 R5 order)", tag, p), act, exp_par[p]);
        end
        check(last_cnt == 1 && last_at == N - 1, "R6", $sformatf("vec %0d last index", tag),
              Z'(last_at), Z'(N - 1));
        check(r5_bad == 0, "R5", $sformatf("vec %0d parity phase handshake faults", tag),
              Z'(r5_bad), '0);
        if (stall) begin
            check(r8_bad == 0, "R8", $sformatf("vec %0d bit changed under stall", tag),
                  Z'(r8_bad), '0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        #1;
        check(out_valid === 1'b0 && out_last === 1'b0, "R1", "outputs in reset",
              Z'({out_valid, out_last}), '0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(in_ready === 1'b1 && out_valid === 1'b0 && out_last === 1'b0, "R1",
              "idle after reset", Z'({in_ready, out_valid, out_last}), Z'(3'b100));
        @(negedge clk);
        out_ready = 1'b0;
        #1;
        check(in_ready === 1'b0, "R2", "ready echoes downstream", Z'(in_ready), '0);
        @(negedge clk);
        out_ready = 1'b1;

        for (int v = 0; v < NV; v++) begin
            if (!wd_hit) run_block(int'(VEC[v][23:21]), int'(VEC[v][20:1]), VEC[v][0], v);
        end

        // R7 reset part-way through a block, then a clean block
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_bit   = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        #1;
        check(out_valid === 1'b0 && out_last === 1'b0, "R1", "outputs during mid-block reset",
              Z'({out_valid, out_last}), '0);
        @(negedge clk);
        rst_n = 1'b1;
        if (!wd_hit) run_block(2, 300, 1'b0, 20);
        if (!wd_hit) run_block(3, 777, 1'b1, 21);

        if (wd_hit) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule